// File: doc/BRIEF.md
# Four-Way Pairwise Recency Tracker

This block holds exact least-recently-used ordering for one set of a four-way set-associative cache. Six ordering bits are kept, one for each unordered pair of ways. Each bit says which way of its pair was touched more recently. A hit or a fill on a way is signalled by a strobe and a way index. On the next clock edge, the tracker rewrites the three bits that involve that way, so that the way becomes the newest of the four.

The replacement choice is formed combinationally from the stored ordering and a per-way lock mask. The chosen way is the unlocked way that every other unlocked way has overtaken. A locked way is never offered. When all four ways are locked, a flag says that no victim exists. For debug, the six ordering bits are always visible, and a write port can load them with any value. Such a value may be inconsistent, meaning the pairwise relations form a cycle. For that case, a fixed fallback rule still names an unlocked way.

Top module: `way_recency_lru`

## Requirements
- R1: A synchronous active-high reset loads the ordering bits with 6'b000000. With no locks, the victim is then way 3.
- R2: Bit k of `orderState` means "the first way of pair k is newer than the second". The pairs are: bit0 3/2, bit1 3/1, bit2 3/0, bit3 2/1, bit4 2/0, bit5 1/0. On an access to way W, each bit where W is the first way becomes 1 and each bit where W is the second way becomes 0. The other bits keep their values.
- R3: An access changes `orderState` only at the clock edge after the strobe is sampled. `victimWay` and `noVictim` follow the current state and `lockMask` with no clock delay.
- R4: A debug write loads `dbgData` into `orderState` at the next edge. If a debug write and an access arrive in the same cycle, the debug write wins.
- R5: In a cycle with no access, no debug write and no reset, `orderState` keeps its value.
- R6: `victimWay` is the lowest-numbered unlocked way that every other unlocked way is newer than. A way whose `lockMask` bit is 1 is never reported as the victim while `noVictim` is 0.
- R7: When `lockMask` is 4'b1111, `noVictim` is 1 and `victimWay` is 0. Otherwise `noVictim` is 0.
- R8: If no unlocked way is overtaken by all other unlocked ways (a cyclic state), `victimWay` is the lowest-numbered unlocked way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| accessValid | input | 1 | Hit or fill strobe for this set |
| accessWay | input | 2 | Way touched by the access |
| lockMask | input | 4 | One bit per way; 1 excludes that way from replacement |
| dbgWrite | input | 1 | Debug load strobe for the ordering bits |
| dbgData | input | 6 | Value loaded by a debug write |
| orderState | output | 6 | Current pairwise ordering bits |
| victimWay | output | 2 | Way to replace |
| noVictim | output | 1 | All ways are locked |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edge. They also assume that `accessWay`, `dbgData` and `lockMask` carry known values whenever their strobes are sampled. The bench drives every input at the falling edge and raises reset before the first rising edge, so both assumptions hold. The victim rules are checked over all 64 ordering values, including the cyclic ones that only a debug write can create, each against all 16 lock masks. The update rule is swept over every state and every accessed way.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Control strobes handed from the control module to the datapath.
  typedef struct packed {
    logic clear;   // synchronous reset of the ordering bits
    logic load;    // debug load of the ordering bits
    logic touch;   // access update of the ordering bits
  } lruStrobes_t;
endpackage

// File: rtl/lru_ctrl.sv
module lru_ctrl
  import lru_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accessValid,
  input  logic [WAY_W-1:0] accessWay,
  input  logic             dbgWrite,
  output lruStrobes_t      strobes,
  output logic [WAY_W-1:0] touchWay
);
  // Priority: reset, then debug load, then access update.
  always_comb begin
    strobes.clear = rst;
    strobes.load  = !rst && dbgWrite;
    strobes.touch = !rst && !dbgWrite && accessValid;
    touchWay      = accessWay;
  end

  // R4: an access that collides with a debug write must not update
  p_dbg_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (dbgWrite && accessValid) |-> !strobes.touch);
endmodule

// File: rtl/lru_datapath.sv
module lru_datapath
  import lru_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int WAY_W     = 2,
  parameter int PAIR_BITS = 6
) (
  input  logic                 clk,
  input  lruStrobes_t          strobes,
  input  logic [WAY_W-1:0]     touchWay,
  input  logic [PAIR_BITS-1:0] loadValue,
  input  logic [NUM_WAYS-1:0]  lockMask,
  output logic [PAIR_BITS-1:0] state,
  output logic [WAY_W-1:0]     victimWay,
  output logic                 noVictim
);
  // Pairs are numbered with the higher way descending, then the lower way descending.
  function automatic int pairIdx(input int hi, input int lo);
    int idx;
    idx = 0;
    for (int h = NUM_WAYS - 1; h > hi; h--) idx += h;
    return idx + (hi - 1 - lo);
  endfunction

  // True when way a was used more recently than way b.
  function automatic logic isNewer(input logic [PAIR_BITS-1:0] st, input int a, input int b);
    if (a > b) return st[pairIdx(a, b)];
    else       return !st[pairIdx(b, a)];
  endfunction

  function automatic logic isMru(input logic [PAIR_BITS-1:0] st, input int w);
    logic ok;
    ok = 1'b1;
    for (int j = 0; j < NUM_WAYS; j++)
      if (j != w && !isNewer(st, w, j)) ok = 1'b0;
    return ok;
  endfunction

  logic [PAIR_BITS-1:0] touchNext;
  logic [NUM_WAYS-1:0]  losesAll;

  // Access update: the touched way wins every pair it belongs to.
  always_comb begin
    touchNext = state;
    for (int hi = 1; hi < NUM_WAYS; hi++) begin
      for (int lo = 0; lo < hi; lo++) begin
        if (int'(touchWay) == hi)      touchNext[pairIdx(hi, lo)] = 1'b1;
        else if (int'(touchWay) == lo) touchNext[pairIdx(hi, lo)] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)      state <= '0;
    else if (strobes.load)  state <= loadValue;
    else if (strobes.touch) state <= touchNext;
  end

  // A way is a candidate when every other unlocked way is newer than it.
  always_comb begin
    for (int i = 0; i < NUM_WAYS; i++) begin
      losesAll[i] = 1'b1;
      for (int j = 0; j < NUM_WAYS; j++)
        if (j != i && !lockMask[j] && !isNewer(state, j, i)) losesAll[i] = 1'b0;
    end
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    victimWay = '0;
    noVictim  = &lockMask;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!found && !lockMask[i] && losesAll[i]) begin
        victimWay = WAY_W'(i);
        found     = 1'b1;
      end
    end
    // Cyclic ordering: fall back to the lowest unlocked way.
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (!found && !lockMask[i]) begin
        victimWay = WAY_W'(i);
        found     = 1'b1;
      end
    end
  end

  // R2: after an access the touched way is newer than all others
  p_touch_mru_r2: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.touch |=> isMru(state, int'($past(touchWay))));

  // R4: a debug load lands on the next edge
  p_load_value_r4: assert property (@(posedge clk) disable iff (strobes.clear)
    strobes.load |=> state == $past(loadValue));

  // R5: no strobe means the ordering is held
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (strobes.clear)
    (!strobes.load && !strobes.touch) |=> $stable(state));

  // R6: a locked way is never offered for replacement
  p_locked_skip_r6: assert property (@(posedge clk) disable iff (strobes.clear)
    !noVictim |-> !lockMask[victimWay]);

  // R7: with no candidate the index rests at zero
  p_none_zero_r7: assert property (@(posedge clk) disable iff (strobes.clear)
    noVictim |-> victimWay == '0);
endmodule

// File: rtl/way_recency_lru.sv
module way_recency_lru
  import lru_pkg::*;
#(
  parameter  int NUM_WAYS  = 4,
  localparam int WAY_W     = $clog2(NUM_WAYS),
  localparam int PAIR_BITS = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accessValid,
  input  logic [WAY_W-1:0]     accessWay,
  input  logic [NUM_WAYS-1:0]  lockMask,
  input  logic                 dbgWrite,
  input  logic [PAIR_BITS-1:0] dbgData,
  output logic [PAIR_BITS-1:0] orderState,
  output logic [WAY_W-1:0]     victimWay,
  output logic                 noVictim
);
  lruStrobes_t      strobes;
  logic [WAY_W-1:0] touchWay;

  lru_ctrl #(.WAY_W(WAY_W)) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .accessValid (accessValid),
    .accessWay   (accessWay),
    .dbgWrite    (dbgWrite),
    .strobes     (strobes),
    .touchWay    (touchWay)
  );

  lru_datapath #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W), .PAIR_BITS(PAIR_BITS)) uPath (
    .clk       (clk),
    .strobes   (strobes),
    .touchWay  (touchWay),
    .loadValue (dbgData),
    .lockMask  (lockMask),
    .state     (orderState),
    .victimWay (victimWay),
    .noVictim  (noVictim)
  );

  // R1: reset clears the ordering bits on the following edge
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> orderState == '0);
endmodule

// File: tb/way_recency_lru_test.sv
`timescale 1ns/1ps
module way_recency_lru_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       accessValid = 1'b0;
  logic [1:0] accessWay = 2'd0;
  logic [3:0] lockMask = 4'd0;
  logic       dbgWrite = 1'b0;
  logic [5:0] dbgData = 6'd0;
  logic [5:0] orderState;
  logic [1:0] victimWay;
  logic       noVictim;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  way_recency_lru uut (
    .clk(clk), .rst(rst), .accessValid(accessValid), .accessWay(accessWay),
    .lockMask(lockMask), .dbgWrite(dbgWrite), .dbgData(dbgData),
    .orderState(orderState), .victimWay(victimWay), .noVictim(noVictim)
  );

  // Bit position of each pair, taken from R2.
  function automatic int bitOf(int hi, int lo);
    if (hi == 3 && lo == 2) return 0;
    if (hi == 3 && lo == 1) return 1;
    if (hi == 3 && lo == 0) return 2;
    if (hi == 2 && lo == 1) return 3;
    if (hi == 2 && lo == 0) return 4;
    return 5;
  endfunction

  function automatic bit mNewer(logic [5:0] s, int a, int b);
    return (a > b) ? s[bitOf(a, b)] : !s[bitOf(b, a)];
  endfunction

  function automatic logic [5:0] mTouch(logic [5:0] s, int w);
    logic [5:0] r;
    r = s;
    for (int j = 0; j < 4; j++) begin
      if (j > w) r[bitOf(j, w)] = 1'b0;
      if (j < w) r[bitOf(w, j)] = 1'b1;
    end
    return r;
  endfunction

  // Returns victim in v; cyc tells whether the fallback rule applied.
  task automatic mVictim(input logic [5:0] s, input logic [3:0] m,
                         output int v, output bit nv, output bit cyc);
    v = -1; nv = (m == 4'hF); cyc = 1'b0;
    for (int i = 0; i < 4; i++) begin
      bit lose;
      lose = 1'b1;
      for (int j = 0; j < 4; j++)
        if (j != i && !m[j] && !mNewer(s, j, i)) lose = 1'b0;
      if (v < 0 && !m[i] && lose) v = i;
    end
    if (v < 0) begin
      cyc = !nv;
      for (int i = 3; i >= 0; i--) if (!m[i]) v = i;
    end
    if (v < 0) v = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic loadState(logic [5:0] s);
    @(negedge clk); dbgWrite = 1'b1; dbgData = s;
    @(negedge clk); dbgWrite = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int v; bit nv; bit cyc;
    repeat (2) @(negedge clk);
    chk("R1 state in reset", orderState, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state after reset", orderState, 0);
    chk("R1 victim after reset", victimWay, 3);
    chk("R7 noVictim clear", noVictim, 0);

    // Every state against every lock mask.
    for (int s = 0; s < 64; s++) begin
      loadState(6'(s));
      chk("R4 debug load", orderState, s);
      for (int m = 0; m < 16; m++) begin
        lockMask = 4'(m);
        #1;
        mVictim(6'(s), 4'(m), v, nv, cyc);
        if (m == 15) chk("R7 victim index", victimWay, 0);
        else if (cyc) chk("R8 cyclic fallback", victimWay, v);
        else chk("R6 victim choice", victimWay, v);
        chk("R7 noVictim flag", noVictim, nv);
      end
      lockMask = 4'd0;
    end

    // Every state with every accessed way.
    for (int s = 0; s < 64; s++) begin
      for (int w = 0; w < 4; w++) begin
        loadState(6'(s));
        @(negedge clk); accessValid = 1'b1; accessWay = 2'(w);
        #1;
        chk("R3 no update before edge", orderState, s);
        @(negedge clk); accessValid = 1'b0;
        chk("R2 access update", orderState, mTouch(6'(s), w));
        mVictim(orderState, 4'd0, v, nv, cyc);
        chk("R3 victim follows state", victimWay, v);
        @(negedge clk);
        chk("R5 hold when idle", orderState, mTouch(6'(s), w));
      end
    end

    // Debug write colliding with an access.
    loadState(6'd0);
    @(negedge clk); dbgWrite = 1'b1; dbgData = 6'h2A; accessValid = 1'b1; accessWay = 2'd1;
    @(negedge clk); dbgWrite = 1'b0; accessValid = 1'b0;
    chk("R4 debug beats access", orderState, 6'h2A);

    // Reset in mid-run.
    loadState(6'h3F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 mid-run reset", orderState, 0);
    chk("R1 victim after mid-run reset", victimWay, 3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule